// File: doc/BRIEF.md
# Load Address Generation and Extension Unit

This unit executes the load group of a 32-bit RISC core. It takes one load at a time, made up of an 8-bit opcode, an 8-bit displacement or sub-field, a destination index and the values of Rj, R13, R14 and R15. It decodes the opcode into an addressing mode and an access size and rebuilds the scaled displacement. It then forms the effective address and issues a word read to memory, holding the request until memory answers.

The answered word is cut to the addressed byte or halfword lane in big-endian order and zero-extended. It is then returned as one write-back pulse. The stack-pop form also produces a new R15 value (old R15 plus 4) in that same pulse. If the pop targets R15 itself, the increment is suppressed so that the loaded value wins. A pop into the status register also raises a four-bit flag update.

The controller has three states. `ST_IDLE` accepts an issue. The transition *accept* (a legal issue while idle) goes to `ST_REQ`. `ST_REQ` drives the memory request. The transition *answer* (`mem_valid` while requesting) goes to `ST_WB`. `ST_WB` drives the write-back for one cycle and always takes the transition *retire* back to `ST_IDLE`. An illegal issue takes the transition *reject*, which leaves the unit in `ST_IDLE`.

Top module: `load_unit`

## Requirements
- R1: Opcode 0x04 loads the word at Rj, and opcode 0x00 loads the word at R13+Rj. The full word is returned with `wb_kind`=0 (general register) and `wb_idx`=`issue_dst`.
- R2: Opcodes 0x20 (word), 0x40 (halfword) and 0x60 (byte) address R14 plus the sign-extended 8-bit `issue_field`. The field is shifted left by 2, 1 and 0 respectively.
- R3: Opcode 0x03 loads the word at R15 plus `issue_field[3:0]`*4, zero-extended. `issue_field[7:4]` has no effect.
- R4: Halfword loads (0x05 at Rj, 0x01 at R13+Rj, 0x40) return bits 31:16 of the read word when address bit 1 is 0, and bits 15:0 when it is 1. The result is zero-extended to 32 bits.
- R5: Byte loads (0x06 at Rj, 0x02 at R13+Rj, 0x60) return the lane chosen by address bits 1:0 in big-endian order. Offset 0 gives bits 31:24 and offset 3 gives bits 7:0. The result is zero-extended.
- R6: `mem_req` rises the cycle after an accepted issue and stays high with a stable `mem_addr` until a cycle where `mem_valid` is high. In the next cycle `wb_en` is high for exactly one cycle.
- R7: Opcode 0x07 with `issue_field[7:4]`=0 reads the word at R15 into general register `issue_dst`. In the same write-back cycle it asserts `sp_wen` with `sp_data` = R15+4.
- R8: Opcode 0x07 with `issue_field[7:4]`=8 writes a special register (`wb_kind`=1, `wb_idx`=`issue_dst`). With `issue_field[7:4]`=9 it writes the status register (`wb_kind`=2) and asserts `flag_wen`, with `flag_nzvc` = N,Z,V,C = loaded bits 3,2,1,0. Both forms also assert `sp_wen` with R15+4.
- R9: A general-register pop with `issue_dst`=15 writes the loaded word and leaves `sp_wen` low.
- R10: An issue with any other opcode, or a pop with any other `issue_field[7:4]`, is ignored. `mem_req` and `wb_en` stay low and `issue_ready` stays high.
- R11: After reset `issue_ready` is high and `mem_req`, `wb_en`, `sp_wen` and `flag_wen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | A load is presented |
| issue_ready | output | 1 | Unit is idle and takes an issue |
| issue_op | input | 8 | Load opcode |
| issue_field | input | 8 | Displacement, offset or pop sub-field |
| issue_dst | input | 4 | Destination register index |
| rj_val | input | 32 | Value of Rj |
| r13_val | input | 32 | Value of R13 |
| r14_val | input | 32 | Value of R14 |
| r15_val | input | 32 | Value of R15 |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Effective byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word |
| wb_en | output | 1 | Write-back pulse |
| wb_kind | output | 2 | 0 general, 1 special, 2 status |
| wb_idx | output | 4 | Destination index |
| wb_data | output | 32 | Extended load result |
| sp_wen | output | 1 | R15 update |
| sp_data | output | 32 | New R15 value |
| flag_wen | output | 1 | Flag update |
| flag_nzvc | output | 4 | N,Z,V,C |

## Verification
The destination write and the R15 increment of a pop fall in the same `ST_WB` cycle. Pops into a general register, a special register and the status register are issued with R15 values the bench knows. In that one cycle the bench compares `wb_data`, `sp_wen` and `sp_data` together. A pop into R15 itself forces the conflict. There the result is judged correct only if the loaded word appears on the write-back and `sp_wen` stays low.

// File: rtl/load_pkg.sv
package load_pkg;
    localparam int XLEN    = 32;
    localparam int LANES   = XLEN / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int FIELD_W = 8;
    localparam int IDX_W   = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WB} state_t;
    typedef enum logic [2:0] {AM_RJ, AM_R13, AM_R14, AM_R15, AM_POP} amode_t;
    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_t;
    typedef enum logic [1:0] {WK_GPR = 2'd0, WK_SPR = 2'd1, WK_STAT = 2'd2} wkind_t;

    typedef struct packed {
        logic   legal;
        amode_t mode;
        size_t  size;
        wkind_t kind;
    } dec_t;
endpackage

// File: rtl/load_decode.sv
module load_decode
    import load_pkg::*;
(
    input  logic [7:0] op,
    input  logic [3:0] sub,
    output dec_t       dec
);
    always_comb begin
        dec = '{legal: 1'b1, mode: AM_RJ, size: SZ_W, kind: WK_GPR};
        unique case (op)
            8'h04: begin dec.mode = AM_RJ;  dec.size = SZ_W; end
            8'h00: begin dec.mode = AM_R13; dec.size = SZ_W; end
            8'h20: begin dec.mode = AM_R14; dec.size = SZ_W; end
            8'h03: begin dec.mode = AM_R15; dec.size = SZ_W; end
            8'h05: begin dec.mode = AM_RJ;  dec.size = SZ_H; end
            8'h01: begin dec.mode = AM_R13; dec.size = SZ_H; end
            8'h40: begin dec.mode = AM_R14; dec.size = SZ_H; end
            8'h06: begin dec.mode = AM_RJ;  dec.size = SZ_B; end
            8'h02: begin dec.mode = AM_R13; dec.size = SZ_B; end
            8'h60: begin dec.mode = AM_R14; dec.size = SZ_B; end
            8'h07: begin
                dec.mode = AM_POP;
                dec.size = SZ_W;
                unique case (sub)
                    4'h0:    dec.kind  = WK_GPR;
                    4'h8:    dec.kind  = WK_SPR;
                    4'h9:    dec.kind  = WK_STAT;
                    default: dec.legal = 1'b0;
                endcase
            end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/load_agen.sv
module load_agen
    import load_pkg::*;
(
    input  amode_t              mode,
    input  size_t               size,
    input  logic [FIELD_W-1:0]  field,
    input  logic [XLEN-1:0]     rj,
    input  logic [XLEN-1:0]     r13,
    input  logic [XLEN-1:0]     r14,
    input  logic [XLEN-1:0]     r15,
    output logic [XLEN-1:0]     addr
);
    logic [XLEN-1:0] disp_sx;
    logic [XLEN-1:0] off_zx;

    assign disp_sx = {{(XLEN-FIELD_W){field[FIELD_W-1]}}, field} << size;
    assign off_zx  = {{(XLEN-6){1'b0}}, field[3:0], 2'b00};

    always_comb begin
        unique case (mode)
            AM_RJ:   addr = rj;
            AM_R13:  addr = r13 + rj;
            AM_R14:  addr = r14 + disp_sx;
            AM_R15:  addr = r15 + off_zx;
            default: addr = r15;
        endcase
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import load_pkg::*;
(
    input  logic [XLEN-1:0]   word,
    input  logic [LANE_W-1:0] lane,
    input  size_t             size,
    output logic [XLEN-1:0]   data
);
    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = '0;
        data    = word;
        unique case (size)
            SZ_B: begin
                shifted = word >> (8 * (LANES - 1 - int'(lane)));
                data    = {{(XLEN-8){1'b0}}, shifted[7:0]};
            end
            SZ_H: begin
                shifted = word >> (16 * (1 - int'(lane[LANE_W-1])));
                data    = {{(XLEN-16){1'b0}}, shifted[15:0]};
            end
            default: data = word;
        endcase
    end
endmodule

// File: rtl/load_unit.sv
module load_unit
    import load_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [7:0]        issue_op,
    input  logic [7:0]        issue_field,
    input  logic [3:0]        issue_dst,
    input  logic [31:0]       rj_val,
    input  logic [31:0]       r13_val,
    input  logic [31:0]       r14_val,
    input  logic [31:0]       r15_val,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    output logic              wb_en,
    output logic [1:0]        wb_kind,
    output logic [3:0]        wb_idx,
    output logic [31:0]       wb_data,
    output logic              sp_wen,
    output logic [31:0]       sp_data,
    output logic              flag_wen,
    output logic [3:0]        flag_nzvc
);
    localparam logic [IDX_W-1:0] SP_IDX  = IDX_W'(15);
    localparam logic [XLEN-1:0]  POP_INC = XLEN'(LANES);

    state_t          state, nxt;
    dec_t            dec, dec_q;
    logic [XLEN-1:0] ea, addr_q, word_q, ext;
    logic [IDX_W-1:0] dst_q;
    logic            accept;

    load_decode u_dec (
        .op  (issue_op),
        .sub (issue_field[7:4]),
        .dec (dec)
    );

    load_agen u_agen (
        .mode  (dec.mode),
        .size  (dec.size),
        .field (issue_field),
        .rj    (rj_val),
        .r13   (r13_val),
        .r14   (r14_val),
        .r15   (r15_val),
        .addr  (ea)
    );

    load_extract u_ext (
        .word (word_q),
        .lane (addr_q[LANE_W-1:0]),
        .size (dec_q.size),
        .data (ext)
    );

    assign accept = (state == ST_IDLE) && issue_valid && dec.legal;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)    nxt = ST_REQ;
            ST_REQ:  if (mem_valid) nxt = ST_WB;
            ST_WB:                  nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            dec_q  <= '{legal: 1'b0, mode: AM_RJ, size: SZ_W, kind: WK_GPR};
            dst_q  <= '0;
            word_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= ea;
                dec_q  <= dec;
                dst_q  <= issue_dst;
            end
            if (state == ST_REQ && mem_valid) word_q <= mem_rdata;
        end
    end

    always_comb begin
        issue_ready = (state == ST_IDLE);
        mem_req     = (state == ST_REQ);
        mem_addr    = addr_q;
        wb_en       = (state == ST_WB);
        wb_kind     = dec_q.kind;
        wb_idx      = dst_q;
        wb_data     = ext;
        sp_wen      = (state == ST_WB) && (dec_q.mode == AM_POP)
                      && !(dec_q.kind == WK_GPR && dst_q == SP_IDX);
        sp_data     = addr_q + POP_INC;
        flag_wen    = (state == ST_WB) && (dec_q.kind == WK_STAT);
        flag_nzvc   = ext[3:0];
    end
endmodule

// File: rtl/load_unit_chk.sv
module load_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        wb_en,
    input logic [1:0]  wb_kind,
    input logic [3:0]  wb_idx,
    input logic        sp_wen,
    input logic [31:0] sp_data,
    input logic        flag_wen
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    p_wb_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> wb_en);

    p_wb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en && issue_ready);

    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wen |-> wb_en && sp_data == $past(mem_addr) + 32'd4);

    p_pop_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && wb_kind == 2'd0 && wb_idx == 4'd15 |-> !sp_wen);

    p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wen |-> wb_en && wb_kind == 2'd2 && sp_wen);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !issue_ready && !wb_en);
endmodule

bind load_unit load_unit_chk u_chk (.*);

// File: tb/load_unit_bench.sv
module load_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [7:0]  issue_op = '0;
    logic [7:0]  issue_field = '0;
    logic [3:0]  issue_dst = '0;
    logic [31:0] rj_val = '0, r13_val = '0, r14_val = '0, r15_val = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [1:0]  wb_kind;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        sp_wen;
    logic [31:0] sp_data;
    logic        flag_wen;
    logic [3:0]  flag_nzvc;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        string       tag;
        logic [31:0] addr;
        int          sz;
        logic [1:0]  kind;
        logic [3:0]  idx;
        logic        sp_en;
        logic [31:0] sp;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    load_unit u_load_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ((a & ~32'h3) * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input int sz);
        logic [31:0] w;
        w = mem_word(a);
        if (sz == 0) return (w >> (8 * (3 - a[1:0]))) & 32'hFF;
        if (sz == 1) return a[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
        return w;
    endfunction

    task automatic issue(input string tag, input logic [7:0] op, input logic [7:0] fld,
                         input logic [3:0] dst, input logic [31:0] rj, input logic [31:0] r13,
                         input logic [31:0] r14, input logic [31:0] r15,
                         input logic [31:0] ea, input int sz, input logic [1:0] kind,
                         input logic sp_en);
        exp_t e;
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        e.tag = tag; e.addr = ea; e.sz = sz; e.kind = kind; e.idx = dst;
        e.sp_en = sp_en; e.sp = r15 + 32'd4;
        exp_q.push_back(e);
        addr_q.push_back(ea);
        tag_q.push_back(tag);
        issue_op = op; issue_field = fld; issue_dst = dst;
        rj_val = rj; r13_val = r13; r14_val = r14; r15_val = r15;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    // memory model: varying latency, checks address and hold (R6)
    initial begin
        logic [31:0] held;
        string       tg;
        int          cnt;
        int          lat;
        bit          seen;
        held = '0; cnt = 0; lat = 0; seen = 0; tg = "";
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
                chk("R6 wb after valid", {31'b0, wb_en}, 32'd1);
                seen = 0;
            end else if (mem_req) begin
                if (!seen) begin
                    seen = 1;
                    held = addr_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(tg, mem_addr, held);
                end else begin
                    chk("R6 address held", mem_addr, held);
                end
                if (cnt == lat) begin
                    mem_rdata = mem_word(mem_addr);
                    mem_valid = 1'b1;
                    cnt = 0;
                    lat = (lat + 1) % 3;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // monitor: scoreboard compare on each write-back
    initial begin
        forever begin
            @(negedge clk);
            if (wb_en) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected write-back", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, {30'b0, wb_kind}, {30'b0, e.kind});
                    if (e.kind != 2'd2) chk(e.tag, {28'b0, wb_idx}, {28'b0, e.idx});
                    chk(e.tag, wb_data, exp_data(e.addr, e.sz));
                    chk(e.tag, {31'b0, sp_wen}, {31'b0, e.sp_en});
                    if (e.sp_en) chk(e.tag, sp_data, e.sp);
                    chk(e.tag, {31'b0, flag_wen}, {31'b0, e.kind == 2'd2});
                    if (e.kind == 2'd2)
                        chk("R8 flags", {28'b0, flag_nzvc}, {28'b0, mem_word(e.addr) & 32'hF});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", {31'b0, issue_ready}, 32'd1);
        chk("R11 req", {31'b0, mem_req}, 32'd0);
        chk("R11 wb", {28'b0, wb_en, sp_wen, flag_wen, 1'b0}, 32'd0);
        rst_n = 1'b1;

        issue("R1 @Rj",      8'h04, 8'h00, 4'd3, 32'h1000_0008, 0, 0, 0, 32'h1000_0008, 2, 2'd0, 0);
        issue("R1 @R13+Rj",  8'h00, 8'h00, 4'd4, 32'h0000_0014, 32'h2000_0000, 0, 0, 32'h2000_0014, 2, 2'd0, 0);
        issue("R2 word neg", 8'h20, 8'hFF, 4'd1, 0, 0, 32'h3000_0100, 0, 32'h3000_00FC, 2, 2'd0, 0);
        issue("R2 word pos", 8'h20, 8'h10, 4'd2, 0, 0, 32'h3000_0100, 0, 32'h3000_0140, 2, 2'd0, 0);
        issue("R3 R15 off",  8'h03, 8'hFF, 4'd6, 0, 0, 0, 32'h4000_0000, 32'h4000_003C, 2, 2'd0, 0);
        issue("R2 R4 half disp", 8'h40, 8'h81, 4'd7, 0, 0, 32'h5000_0200, 0, 32'h5000_0102, 1, 2'd0, 0);
        issue("R4 half Rj",  8'h05, 8'h00, 4'd8, 32'h6000_0000, 0, 0, 0, 32'h6000_0000, 1, 2'd0, 0);
        issue("R4 half R13", 8'h01, 8'h00, 4'd9, 32'h0000_0006, 32'h6000_0000, 0, 0, 32'h6000_0006, 1, 2'd0, 0);
        issue("R2 R5 byte disp", 8'h60, 8'h80, 4'd10, 0, 0, 32'h7000_0083, 0, 32'h7000_0003, 0, 2'd0, 0);
        issue("R5 byte Rj",  8'h06, 8'h00, 4'd11, 32'h7000_0001, 0, 0, 0, 32'h7000_0001, 0, 2'd0, 0);
        issue("R5 byte R13", 8'h02, 8'h00, 4'd12, 32'h0000_0002, 32'h7100_0000, 0, 0, 32'h7100_0002, 0, 2'd0, 0);
        issue("R5 byte lane0", 8'h06, 8'h00, 4'd13, 32'h7200_0004, 0, 0, 0, 32'h7200_0004, 0, 2'd0, 0);
        issue("R7 pop gpr",  8'h07, 8'h05, 4'd5, 0, 0, 0, 32'h8000_0010, 32'h8000_0010, 2, 2'd0, 1);
        issue("R8 pop spr",  8'h07, 8'h80, 4'd2, 0, 0, 0, 32'h8000_0020, 32'h8000_0020, 2, 2'd1, 1);
        issue("R8 pop status", 8'h07, 8'h90, 4'd0, 0, 0, 0, 32'h8000_0030, 32'h8000_0030, 2, 2'd2, 1);
        issue("R9 pop to R15", 8'h07, 8'h00, 4'd15, 0, 0, 0, 32'h8000_0040, 32'h8000_0040, 2, 2'd0, 0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);

        // R10 illegal issues are ignored
        issue_op = 8'h10; issue_field = 8'h00; issue_valid = 1'b1;
        @(negedge clk);
        issue_op = 8'h07; issue_field = 8'h30;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 no request", {31'b0, mem_req}, 32'd0);
            chk("R10 still ready", {31'b0, issue_ready}, 32'd1);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule